// File: doc/BRIEF.md
# Hashed Translation Table Lookup Unit

This block serves translation misses by probing a direct-mapped table of tag/translation pairs held in memory. A lookup request carries a faulting virtual address and a context number. From these the block forms the address of one 16-byte slot and a 64-bit comparison tag. It fetches the whole slot in one 128-bit read. It then answers with a hit flag and the translation word, or with a miss.

The same block also installs entries. An update first polls the slot until the slot's lock flag is clear. It then claims the lock with a compare-and-swap on the upper half of the stored tag, and retries from the poll if another writer got there first. Next it writes the translation word and issues a store-ordering fence. Last it writes the final tag, and that write releases the lock. Only one request, lookup or update, is in flight at a time.

The controller is a single state machine with these states:
- `ST_IDLE`: accepts a request; a lookup wins over an update.
- `ST_LK_READ`: slot read for a lookup.
- `ST_LK_REPLY`: the one-cycle `lk_done` pulse.
- `ST_UP_POLL`: lock poll.
- `ST_UP_LOCK`: compare-and-swap.
- `ST_UP_DATA`: translation write.
- `ST_UP_FENCE`: fence.
- `ST_UP_TAG`: tag write.
- `ST_UP_REPLY`: the one-cycle `up_done` pulse.

The transitions are named as follows:
- IDLE→LK_READ on `lk_valid`.
- IDLE→UP_POLL on `up_valid` with no lookup pending.
- LK_READ→LK_REPLY on `mem_ack`.
- UP_POLL→UP_POLL when an acknowledged read shows the lock set, and UP_POLL→UP_LOCK when it shows the lock clear.
- UP_LOCK→UP_DATA when the returned old word equals the compare value, and UP_LOCK→UP_POLL otherwise.
- UP_DATA→UP_FENCE, UP_FENCE→UP_TAG and UP_TAG→UP_REPLY, each on `mem_ack`.
- LK_REPLY→IDLE and UP_REPLY→IDLE, unconditionally.

Top module: `hxt_unit`

## Requirements
- R1: After reset, `lk_ready` and `up_ready` are 1, and `mem_req`, `lk_done` and `up_done` are 0.
- R2: A lookup issues exactly one memory operation. It is a 128-bit read (`mem_op`=0) at `base_addr + vaddr[21:13]*16`. `mem_rdata[63:0]` returns the stored tag and `mem_rdata[127:64]` returns the translation word.
- R3: The comparison tag has the context in bits [60:48] and vaddr[63:22] in bits [41:0], with all other bits 0. A hit is reported only when all 64 bits of the stored tag equal it, and the hit returns the stored translation word on `lk_xlate`.
- R4: A miss returns `lk_xlate`=0. A stored tag with bit 47 (the lock flag) set always misses. A stored tag of all zeros always misses, even against an all-zero comparison tag.
- R5: While a request is in progress, both ready outputs are 0. When a lookup and an update are both requested in idle, the lookup is taken first and `up_ready` is 0 in that cycle.
- R6: An update starts by reading the slot (`mem_op`=0). It repeats this read for as long as the returned tag has bit 47 set.
- R7: The update then issues a compare-and-swap (`mem_op`=2) at the slot address. The compare value `mem_cmp` is the upper tag word last read, and `mem_wdata[31:0]` is that word with bit 15 (tag bit 47) set. If the returned old word (`mem_rdata[31:0]`) differs from the compare value, the update returns to polling.
- R8: After a successful swap, the update writes (`mem_op`=1) the new translation at slot+8, then issues a fence (`mem_op`=3), then writes the comparison tag at slot+0 with the lock flag clear, and then pulses `up_done`.
- R9: While `mem_req` is high and not acknowledged, `mem_op`, `mem_addr` and `mem_wdata` hold steady.
- R10: `lk_done` and `up_done` are each high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 64 | Byte address of slot 0 of the table |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vaddr | input | 64 | Faulting virtual address |
| lk_ctx | input | 13 | Faulting context number |
| lk_done | output | 1 | Lookup result pulse |
| lk_hit | output | 1 | Lookup hit, valid with lk_done |
| lk_xlate | output | 64 | Translation word on hit, zero on miss |
| up_valid | input | 1 | Update request valid |
| up_ready | output | 1 | Update request accepted this cycle |
| up_vaddr | input | 64 | Virtual address of the entry to install |
| up_ctx | input | 13 | Context of the entry to install |
| up_xlate | input | 64 | Translation word to install |
| up_done | output | 1 | Update complete pulse |
| mem_req | output | 1 | Memory operation request |
| mem_op | output | 2 | 0 read 128, 1 write 64, 2 compare-and-swap upper tag word, 3 fence |
| mem_addr | output | 64 | Byte address of the operation |
| mem_wdata | output | 64 | Write data, or swap value in bits [31:0] |
| mem_cmp | output | 32 | Compare value for compare-and-swap |
| mem_ack | input | 1 | Operation complete, data valid |
| mem_rdata | input | 128 | Read data, or old upper tag word in bits [31:0] |

## Verification
The bench drives lookups whose tags differ from a stored tag in one field at a time: context only, top address bit only, or the lock flag only. Each of these must miss, which shows that the compare covers all 64 bits and that the lock flag alone defeats a match. An all-zero address in context zero against an empty slot shows that the invalid marker is rejected, not matched. Updates run against a slot that stays locked for three polls, and against a competing writer that changes the tag just before the swap, so the operation log shows both the poll loop and the retry path. Random mixes of updates and lookups over a few aliasing slots, with random memory latency, show that the results follow a reference table kept by the bench.

// File: rtl/hxt_pkg.sv
package hxt_pkg;
    localparam int VA_W       = 64;
    localparam int WORD_W     = 64;
    localparam int HALF_W     = WORD_W / 2;
    localparam int CTX_W      = 13;
    localparam int IDX_W      = 9;
    localparam int PG_SHIFT   = 13;
    localparam int SLOT_SHIFT = 4;
    localparam int CTX_LSB    = 48;
    localparam int LOCK_POS   = 47;
    localparam int VPN_W      = VA_W - PG_SHIFT;
    localparam int VTAG_W     = VPN_W - IDX_W;
    localparam int XL_OFFSET  = 8;
    localparam logic [HALF_W-1:0] LOCK_HI = HALF_W'(1) << (LOCK_POS - HALF_W);

    typedef enum logic [1:0] {
        MOP_RD128 = 2'd0,
        MOP_WR64  = 2'd1,
        MOP_CAS32 = 2'd2,
        MOP_FENCE = 2'd3
    } mem_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LK_READ, ST_LK_REPLY,
        ST_UP_POLL, ST_UP_LOCK, ST_UP_DATA, ST_UP_FENCE, ST_UP_TAG, ST_UP_REPLY
    } hxt_state_e;
endpackage

// File: rtl/hxt_keygen.sv
module hxt_keygen
    import hxt_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [VA_W-1:0]   base,
    output logic [VA_W-1:0]   slot_addr,
    output logic [WORD_W-1:0] cmp_tag
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx       = vpn[IDX_W-1:0];
        slot_addr = base + {{(VA_W-IDX_W-SLOT_SHIFT){1'b0}}, idx, {SLOT_SHIFT{1'b0}}};
        cmp_tag   = '0;
        cmp_tag[CTX_LSB +: CTX_W] = ctx;
        cmp_tag[VTAG_W-1:0]       = vpn[VPN_W-1:IDX_W];
    end
endmodule

// File: rtl/hxt_ctrl.sv
module hxt_ctrl
    import hxt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [CTX_W-1:0]    lk_ctx,
    input  logic                up_valid,
    input  logic [VPN_W-1:0]    up_vpn,
    input  logic [CTX_W-1:0]    up_ctx,
    input  logic [WORD_W-1:0]   up_xlate,
    input  logic [VA_W-1:0]     slot_addr,
    input  logic [WORD_W-1:0]   cmp_tag,
    input  logic                mem_ack,
    input  logic [2*WORD_W-1:0] mem_rdata,
    output logic                lk_ready,
    output logic                lk_done,
    output logic                lk_hit,
    output logic [WORD_W-1:0]   lk_xlate,
    output logic                up_ready,
    output logic                up_done,
    output logic                mem_req,
    output logic [1:0]          mem_op,
    output logic [VA_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [HALF_W-1:0]   mem_cmp,
    output logic [VPN_W-1:0]    cur_vpn,
    output logic [CTX_W-1:0]    cur_ctx
);
    hxt_state_e          state, state_nx;
    logic [WORD_W-1:0]   cur_xl;
    logic [HALF_W-1:0]   seen_hi;
    logic                hit_q;
    logic [WORD_W-1:0]   xl_q;
    logic                rd_match;

    assign rd_match = (mem_rdata[WORD_W-1:0] == cmp_tag) && (mem_rdata[WORD_W-1:0] != '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (lk_valid) state_nx = ST_LK_READ;
                         else if (up_valid) state_nx = ST_UP_POLL;
            ST_LK_READ:  if (mem_ack) state_nx = ST_LK_REPLY;
            ST_LK_REPLY: state_nx = ST_IDLE;
            ST_UP_POLL:  if (mem_ack) state_nx = mem_rdata[LOCK_POS] ? ST_UP_POLL : ST_UP_LOCK;
            ST_UP_LOCK:  if (mem_ack) state_nx = (mem_rdata[HALF_W-1:0] == seen_hi) ? ST_UP_DATA : ST_UP_POLL;
            ST_UP_DATA:  if (mem_ack) state_nx = ST_UP_FENCE;
            ST_UP_FENCE: if (mem_ack) state_nx = ST_UP_TAG;
            ST_UP_TAG:   if (mem_ack) state_nx = ST_UP_REPLY;
            ST_UP_REPLY: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vpn <= '0;
            cur_ctx <= '0;
            cur_xl  <= '0;
            seen_hi <= '0;
            hit_q   <= 1'b0;
            xl_q    <= '0;
        end else begin
            if (state == ST_IDLE) begin
                if (lk_valid) begin
                    cur_vpn <= lk_vpn;
                    cur_ctx <= lk_ctx;
                end else if (up_valid) begin
                    cur_vpn <= up_vpn;
                    cur_ctx <= up_ctx;
                    cur_xl  <= up_xlate;
                end
            end
            if (state == ST_LK_READ && mem_ack) begin
                hit_q <= rd_match;
                xl_q  <= rd_match ? mem_rdata[2*WORD_W-1:WORD_W] : '0;
            end
            if (state == ST_UP_POLL && mem_ack)
                seen_hi <= mem_rdata[WORD_W-1:HALF_W];
        end
    end

    always_comb begin
        lk_ready  = (state == ST_IDLE);
        up_ready  = (state == ST_IDLE) && !lk_valid;
        lk_done   = (state == ST_LK_REPLY);
        up_done   = (state == ST_UP_REPLY);
        lk_hit    = hit_q;
        lk_xlate  = xl_q;
        mem_req   = 1'b0;
        mem_op    = MOP_RD128;
        mem_addr  = slot_addr;
        mem_wdata = '0;
        mem_cmp   = seen_hi;
        unique case (state)
            ST_LK_READ, ST_UP_POLL: mem_req = 1'b1;
            ST_UP_LOCK: begin
                mem_req   = 1'b1;
                mem_op    = MOP_CAS32;
                mem_wdata = {{HALF_W{1'b0}}, seen_hi | LOCK_HI};
            end
            ST_UP_DATA: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WR64;
                mem_addr  = slot_addr + VA_W'(XL_OFFSET);
                mem_wdata = cur_xl;
            end
            ST_UP_FENCE: begin
                mem_req = 1'b1;
                mem_op  = MOP_FENCE;
            end
            ST_UP_TAG: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WR64;
                mem_wdata = cmp_tag;
            end
            default: ;
        endcase
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op) && $stable(mem_addr) && $stable(mem_wdata)));
    // R4
    lock_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LK_READ && mem_ack && mem_rdata[LOCK_POS]) |=> (lk_done && !lk_hit));
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> (lk_xlate == '0));
    // R8
    tag_after_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_op == MOP_FENCE) |=>
        (mem_req && mem_op == MOP_WR64 && mem_addr == $past(mem_addr) && mem_wdata[LOCK_POS] == 1'b0));
    // R7
    swap_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == MOP_CAS32) |-> (mem_wdata[LOCK_POS-HALF_W] && !mem_cmp[LOCK_POS-HALF_W]));
    // R10
    lk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_done |=> !lk_done);
    // R10
    up_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) up_done |=> !up_done);
    // R5
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!lk_ready && !up_ready));
endmodule

// File: rtl/hxt_unit.sv
module hxt_unit
    import hxt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VA_W-1:0]     base_addr,
    input  logic                lk_valid,
    output logic                lk_ready,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [CTX_W-1:0]    lk_ctx,
    output logic                lk_done,
    output logic                lk_hit,
    output logic [WORD_W-1:0]   lk_xlate,
    input  logic                up_valid,
    output logic                up_ready,
    input  logic [VA_W-1:0]     up_vaddr,
    input  logic [CTX_W-1:0]    up_ctx,
    input  logic [WORD_W-1:0]   up_xlate,
    output logic                up_done,
    output logic                mem_req,
    output logic [1:0]          mem_op,
    output logic [VA_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [HALF_W-1:0]   mem_cmp,
    input  logic                mem_ack,
    input  logic [2*WORD_W-1:0] mem_rdata
);
    logic [VPN_W-1:0]  cur_vpn;
    logic [CTX_W-1:0]  cur_ctx;
    logic [VA_W-1:0]   slot_addr;
    logic [WORD_W-1:0] cmp_tag;
    logic              unused_offset_bits;

    assign unused_offset_bits = ^{lk_vaddr[PG_SHIFT-1:0], up_vaddr[PG_SHIFT-1:0]};

    hxt_keygen u_keygen (
        .vpn       (cur_vpn),
        .ctx       (cur_ctx),
        .base      (base_addr),
        .slot_addr (slot_addr),
        .cmp_tag   (cmp_tag)
    );

    hxt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vpn    (lk_vaddr[VA_W-1:PG_SHIFT]),
        .lk_ctx    (lk_ctx),
        .up_valid  (up_valid),
        .up_vpn    (up_vaddr[VA_W-1:PG_SHIFT]),
        .up_ctx    (up_ctx),
        .up_xlate  (up_xlate),
        .slot_addr (slot_addr),
        .cmp_tag   (cmp_tag),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .lk_ready  (lk_ready),
        .lk_done   (lk_done),
        .lk_hit    (lk_hit),
        .lk_xlate  (lk_xlate),
        .up_ready  (up_ready),
        .up_done   (up_done),
        .mem_req   (mem_req),
        .mem_op    (mem_op),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_cmp   (mem_cmp),
        .cur_vpn   (cur_vpn),
        .cur_ctx   (cur_ctx)
    );
endmodule

// File: tb/hxt_unit_tb.sv
`timescale 1ns/1ps
module hxt_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  base_addr = 64'h0000_0040_0010_0000;
    logic         lk_valid = 1'b0, up_valid = 1'b0;
    logic [63:0]  lk_vaddr = '0, up_vaddr = '0, up_xlate = '0;
    logic [12:0]  lk_ctx = '0, up_ctx = '0;
    logic         lk_ready, lk_done, lk_hit, up_ready, up_done, mem_req;
    logic [63:0]  lk_xlate, mem_addr, mem_wdata;
    logic [1:0]   mem_op;
    logic [31:0]  mem_cmp;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    hxt_unit u_dut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [63:0] tg_m [0:511];
    logic [63:0] xl_m [0:511];
    logic [1:0]  log_op [0:31];
    logic [63:0] log_addr [0:31];
    logic [63:0] log_wd [0:31];
    logic [31:0] log_cmp [0:31];
    logic [31:0] log_old [0:31];
    int log_n = 0, wait_c = 0, stab_err = 0, rel_cnt = 0;
    bit steal = 0, have_pend = 0;
    logic [1:0]  p_op;
    logic [63:0] p_addr, p_wd;

    function automatic logic [63:0] f_tag(input logic [63:0] va, input logic [12:0] ctx);
        logic [63:0] t = '0;
        t[60:48] = ctx;
        t[41:0]  = va[63:22];
        return t;
    endfunction
    function automatic int f_slot(input logic [63:0] va);
        return int'(va[21:13]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // memory model with random latency, operation log and stability monitor
    always @(negedge clk) begin
        logic [63:0] off;
        int sl;
        logic [31:0] old;
        if (!rst_n) begin
            mem_ack = 1'b0; wait_c = 0; have_pend = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (have_pend && (mem_op !== p_op || mem_addr !== p_addr || mem_wdata !== p_wd)) stab_err++;
            have_pend = 1; p_op = mem_op; p_addr = mem_addr; p_wd = mem_wdata;
            if (wait_c != 0) wait_c--;
            else begin
                off = mem_addr - base_addr;
                sl = int'(off[12:4]);
                old = '0;
                case (mem_op)
                    2'd0: begin
                        mem_rdata = {xl_m[sl], tg_m[sl]};
                        if (rel_cnt > 0) begin
                            rel_cnt--;
                            if (rel_cnt == 0) tg_m[sl][47] = 1'b0;
                        end
                    end
                    2'd1: if (off[3]) xl_m[sl] = mem_wdata; else tg_m[sl] = mem_wdata;
                    2'd2: begin
                        if (steal) begin tg_m[sl][32] = ~tg_m[sl][32]; steal = 0; end
                        old = tg_m[sl][63:32];
                        mem_rdata = {96'd0, old};
                        if (old == mem_cmp) tg_m[sl][63:32] = mem_wdata[31:0];
                    end
                    default: ;
                endcase
                if (log_n < 32) begin
                    log_op[log_n] = mem_op; log_addr[log_n] = mem_addr; log_wd[log_n] = mem_wdata;
                    log_cmp[log_n] = mem_cmp; log_old[log_n] = old;
                    log_n++;
                end
                mem_ack = 1'b1; have_pend = 0;
                wait_c = $urandom_range(2, 0);
            end
        end
    end

    task automatic do_lookup(input logic [63:0] va, input logic [12:0] ctx,
                             output logic hit, output logic [63:0] xl);
        int t = 0;
        @(negedge clk);
        log_n = 0;
        lk_vaddr = va; lk_ctx = ctx; lk_valid = 1'b1;
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        while (!lk_done && t < 200) begin @(negedge clk); t++; end
        hit = lk_hit; xl = lk_xlate;
        @(negedge clk);
        // R10: done is a single-cycle pulse
        chk(!lk_done && t < 200, "R10 lk_done pulse", {127'd0, lk_done}, 128'd0);
    endtask

    task automatic do_update(input logic [63:0] va, input logic [12:0] ctx, input logic [63:0] xl);
        int t = 0;
        @(negedge clk);
        log_n = 0;
        up_vaddr = va; up_ctx = ctx; up_xlate = xl; up_valid = 1'b1;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        while (!up_done && t < 400) begin @(negedge clk); t++; end
        @(negedge clk);
        chk(!up_done && t < 400, "R10 up_done pulse", {127'd0, up_done}, 128'd0);
    endtask

    // verifies the tail of an update log: swap, data write, fence, tag write
    task automatic chk_update_log(input logic [63:0] va, input logic [12:0] ctx, input logic [63:0] xl);
        logic [63:0] sa = base_addr + {45'd0, va[21:13], 4'd0};
        bit ok;
        ok = (log_n >= 5) && log_op[log_n-4] == 2'd2 && log_addr[log_n-4] == sa &&
             log_op[log_n-3] == 2'd1 && log_addr[log_n-3] == sa + 64'd8 && log_wd[log_n-3] == xl &&
             log_op[log_n-2] == 2'd3 &&
             log_op[log_n-1] == 2'd1 && log_addr[log_n-1] == sa && log_wd[log_n-1] == f_tag(va, ctx);
        chk(ok, "R8 update order", {log_op[log_n-3], log_op[log_n-2], log_op[log_n-1]}, {2'd1, 2'd3, 2'd1});
        chk(log_wd[log_n-4][31:0] == (log_cmp[log_n-4] | 32'h8000), "R7 swap value",
            log_wd[log_n-4][31:0], log_cmp[log_n-4] | 32'h8000);
    endtask

    initial begin
        logic hit;
        logic [63:0] xl, va1, sa;
        int nrd, ncas, t;
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) begin tg_m[i] = '0; xl_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(lk_ready && up_ready && !mem_req && !lk_done && !up_done, "R1 reset state",
            {lk_ready, up_ready, mem_req, lk_done, up_done}, 5'b11000);

        // directed install then hit
        va1 = 64'hABCD_1234_5678_A000;
        do_update(va1, 13'h005, 64'h1111_2222_3333_4444);
        chk_update_log(va1, 13'h005, 64'h1111_2222_3333_4444);
        do_lookup(va1, 13'h005, hit, xl);
        sa = base_addr + {45'd0, va1[21:13], 4'd0};
        // R2
        chk(log_n == 1 && log_op[0] == 2'd0 && log_addr[0] == sa, "R2 single slot read",
            {log_op[0], log_addr[0]}, {2'd0, sa});
        // R3
        chk(hit && xl == 64'h1111_2222_3333_4444, "R3 hit returns word", {hit, xl}, {1'b1, 64'h1111_2222_3333_4444});

        // context differs only
        do_lookup(va1, 13'h006, hit, xl);
        chk(!hit && xl == 0, "R3 ctx mismatch miss, R4 zero word", {hit, xl}, 65'd0);
        // top address bit differs only
        do_lookup(va1 ^ 64'h8000_0000_0000_0000, 13'h005, hit, xl);
        chk(!hit && xl == 0, "R3 full compare miss", {hit, xl}, 65'd0);

        // lock flag forces a miss
        tg_m[f_slot(va1)][47] = 1'b1;
        do_lookup(va1, 13'h005, hit, xl);
        chk(!hit && xl == 0, "R4 locked slot miss", {hit, xl}, 65'd0);

        // update waits for lock release: three locked reads, then one clear
        rel_cnt = 3;
        do_update(va1, 13'h005, 64'h5555_6666_7777_8888);
        nrd = 0;
        for (int i = 0; i < log_n; i++) if (log_op[i] == 2'd0) nrd++;
        // R6
        chk(nrd == 4 && log_op[4] == 2'd2, "R6 poll until unlocked", nrd, 4);
        chk_update_log(va1, 13'h005, 64'h5555_6666_7777_8888);
        do_lookup(va1, 13'h005, hit, xl);
        chk(hit && xl == 64'h5555_6666_7777_8888, "R3 hit after locked update", {hit, xl}, {1'b1, 64'h5555_6666_7777_8888});

        // all-zero tag is invalid
        do_lookup(64'h0000_0000_0000_4000, 13'h000, hit, xl);
        chk(!hit && xl == 0, "R4 zero tag miss", {hit, xl}, 65'd0);

        // competing writer changes the tag just before the swap
        steal = 1;
        do_update(64'h0000_7777_0020_6000, 13'h01F, 64'hDEAD_BEEF_0000_0001);
        ncas = 0;
        for (int i = 0; i < log_n; i++) if (log_op[i] == 2'd2) ncas++;
        // R7
        chk(ncas == 2 && log_old[1] != log_cmp[1], "R7 swap retry", ncas, 2);
        chk_update_log(64'h0000_7777_0020_6000, 13'h01F, 64'hDEAD_BEEF_0000_0001);
        do_lookup(64'h0000_7777_0020_6000, 13'h01F, hit, xl);
        chk(hit && xl == 64'hDEAD_BEEF_0000_0001, "R3 hit after retry", {hit, xl}, {1'b1, 64'hDEAD_BEEF_0000_0001});

        // R5: simultaneous requests, lookup first
        @(negedge clk);
        lk_vaddr = va1; lk_ctx = 13'h005; lk_valid = 1'b1;
        up_vaddr = 64'h0000_0001_0040_2000; up_ctx = 13'h002; up_xlate = 64'h99; up_valid = 1'b1;
        #0.1;
        chk(lk_ready && !up_ready, "R5 lookup priority ready", {lk_ready, up_ready}, 2'b10);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(!lk_ready && !up_ready, "R5 busy not ready", {lk_ready, up_ready}, 2'b00);
        t = 0;
        while (!lk_done && !up_done && t < 200) begin @(negedge clk); t++; end
        chk(lk_done && !up_done, "R5 lookup served first", {lk_done, up_done}, 2'b10);
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        t = 0;
        while (!up_done && t < 400) begin @(negedge clk); t++; end
        chk(up_done, "R5 update served second", up_done, 1);

        // random mix over aliasing slots
        for (int it = 0; it < 80; it++) begin
            logic [63:0] va, ex;
            logic [12:0] cx;
            logic exh;
            va = {($urandom_range(3, 0) == 0) ? 32'h0 : 32'h0000_00A0 + 32'($urandom_range(3, 0)),
                  32'h0040_0000 + (32'($urandom_range(7, 0)) << 13)};
            cx = 13'($urandom_range(3, 0));
            if ($urandom_range(1, 0) == 1) do_update(va, cx, {$urandom, $urandom});
            exh = (tg_m[f_slot(va)] == f_tag(va, cx)) && (tg_m[f_slot(va)] != 0);
            ex = exh ? xl_m[f_slot(va)] : 64'd0;
            do_lookup(va, cx, hit, xl);
            chk(hit == exh && xl == ex, "R3 random lookup", {hit, xl}, {exh, ex});
        end

        // R9
        chk(stab_err == 0, "R9 request stability", stab_err, 0);
        finish_run();
    end
endmodule